// File: doc/BRIEF.md
# Single-Wire VCOM Step Adjuster

This block owns the 10-bit VCOM code of a display reference generator and lets two sources change it: a three-level control pin and an I2C register write. The pin's analog level has already been decoded upstream into two flags, `pin_high` and `pin_low`; with both flags clear the pin is at its resting float level. A qualified excursion to high raises the code by one LSB, and a qualified excursion to low lowers it by one LSB. The step is applied only when the pin has returned to float. Pulse width is measured in ticks of an external 1 µs strobe, and a pulse that is too short is dropped as a glitch. After every pulse, the pin must rest at float for a set number of ticks before a new pulse is accepted.

Every update of the code passes through a saturating clamp bounded by `win_min` and `win_max`. This applies both to a step and to an I2C write. The two sources exclude each other. A pulse is not started while `i2c_active` reports an I2C command in progress. While a pulse is being measured or its step is being committed, `sw_busy` is high so that the I2C side withholds its acknowledge, and the write port deasserts `i2c_wr_ready`.

The I2C write port is a valid/ready stream. The source raises `i2c_wr_valid` with `i2c_wr_code` and holds both stable until it sees `i2c_wr_ready` high at a rising clock edge. The transfer happens on that edge. `i2c_wr_ready` is low exactly while `sw_busy` is high, so a write offered during a pulse is held back, not lost.

Top module: `vcom_step_adjuster`

## Requirements
- R1: After reset, `vcom_code` equals RESET_CODE (default 512), `sw_busy` is 0 and `i2c_wr_ready` is 1.
- R2: A high pulse, taken as `pin_high`=1 with `pin_low`=0, is qualified when at least MIN_TICKS (default 20) `us_tick` strobes are seen while it lasts. It increases `vcom_code` by one on the second rising edge after the pin returns to float.
- R3: A qualified low pulse, taken as `pin_low`=1 with `pin_high`=0, decreases `vcom_code` by one, with the same timing as R2.
- R4: A pulse that spans fewer than MIN_TICKS strobes leaves `vcom_code` unchanged.
- R5: After any pulse, the pin must stay at float for GAP_TICKS (default 10) strobes before a new pulse is accepted. A pulse that arrives sooner is ignored and restarts the float count.
- R6: While `sw_enable` is 0, the pin flags are ignored and no step occurs.
- R7: A pulse that begins while `i2c_active` is 1 is ignored.
- R8: `sw_busy` is 1 from the cycle after a pulse is accepted until its step is committed, and `i2c_wr_ready` is 0 during that time. A write held at the port completes once `sw_busy` falls, so it lands after the step.
- R9: A write of value v loads `win_min` if v < `win_min`, loads `win_max` if v > `win_max`, and loads v otherwise. The lower bound is tested first.
- R10: Steps saturate: a step up from `win_max`, or from 1023, yields `win_max`, and a step down from `win_min`, or from 0, yields `win_min`.
- R11: A pulse that switches directly from one level to the other without passing through float is discarded and no step occurs.
- R12: With no write and no committed step, `vcom_code` holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sw_enable | input | 1 | Enables the single-wire pin |
| pin_high | input | 1 | Decoded pin level is high |
| pin_low | input | 1 | Decoded pin level is low |
| us_tick | input | 1 | One-cycle strobe every microsecond |
| i2c_active | input | 1 | An I2C command is in progress |
| i2c_wr_valid | input | 1 | I2C write request valid |
| i2c_wr_ready | output | 1 | Write accepted on this edge when valid |
| i2c_wr_code | input | 10 | Code to write |
| win_min | input | 10 | Lower clamp bound |
| win_max | input | 10 | Upper clamp bound |
| vcom_code | output | 10 | Current VCOM code |
| sw_busy | output | 1 | Single-wire operation in progress; I2C must not acknowledge |

## Verification
The step commit of a pulse and an I2C write are the two updates that could hit the code register in the same cycle. To provoke this, the bench raises a write request in the middle of a high pulse and holds it there while the pulse ends. It then checks three things. `i2c_wr_ready` is low throughout the pulse. The cycle after the step shows the code one LSB higher with ready raised. The following cycle shows the clamped written value, so neither update is lost and the order is the step first, then the write.

// File: rtl/vsa_pkg.sv
package vsa_pkg;
  typedef enum logic [1:0] {
    S_IDLE = 2'd0,
    S_HIGH = 2'd1,
    S_LOW  = 2'd2,
    S_GAP  = 2'd3
  } pin_state_t;
endpackage

// File: rtl/vsa_clamp.sv
module vsa_clamp #(
  parameter int CODE_W = 10
) (
  input  logic signed [CODE_W+1:0] cand,
  input  logic        [CODE_W-1:0] lo,
  input  logic        [CODE_W-1:0] hi,
  output logic        [CODE_W-1:0] result
);
  logic signed [CODE_W+1:0] lo_ext, hi_ext;

  always_comb begin
    lo_ext = signed'({2'b00, lo});
    hi_ext = signed'({2'b00, hi});
    if (cand < lo_ext)      result = lo;
    else if (cand > hi_ext) result = hi;
    else                    result = cand[CODE_W-1:0];
  end
endmodule

// File: rtl/vsa_pulse_qual.sv
module vsa_pulse_qual
  import vsa_pkg::*;
#(
  parameter int MIN_TICKS = 20,
  parameter int GAP_TICKS = 10
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic lvl_hi,
  input  logic lvl_lo,
  input  logic us_tick,
  input  logic i2c_active,
  output logic step_up,
  output logic step_dn,
  output logic busy
);
  localparam int LIM   = (MIN_TICKS > GAP_TICKS) ? MIN_TICKS : GAP_TICKS;
  localparam int CNT_W = $clog2(LIM + 1);
  localparam logic [CNT_W-1:0] MIN_C = CNT_W'(MIN_TICKS);
  localparam logic [CNT_W-1:0] GAP_C = CNT_W'(GAP_TICKS - 1);
  localparam logic [CNT_W-1:0] LIM_C = CNT_W'(LIM);

  pin_state_t       state;
  logic [CNT_W-1:0] cnt;
  logic             is_float, only_hi, only_lo;

  assign is_float = !(lvl_hi || lvl_lo);
  assign only_hi  = lvl_hi && !lvl_lo;
  assign only_lo  = lvl_lo && !lvl_hi;
  assign busy     = (state == S_HIGH) || (state == S_LOW) || step_up || step_dn;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= S_IDLE;
      cnt     <= '0;
      step_up <= 1'b0;
      step_dn <= 1'b0;
    end else begin
      step_up <= 1'b0;
      step_dn <= 1'b0;
      if (!en) begin
        state <= S_IDLE;
        cnt   <= '0;
      end else begin
        case (state)
          S_IDLE: begin
            cnt <= '0;
            if (!i2c_active) begin
              if (only_hi)      state <= S_HIGH;
              else if (only_lo) state <= S_LOW;
            end
          end
          S_HIGH: begin
            if (is_float) begin
              state   <= S_GAP;
              cnt     <= '0;
              step_up <= (cnt >= MIN_C);
            end else if (lvl_lo) begin
              state <= S_GAP;
              cnt   <= '0;
            end else if (us_tick && cnt < LIM_C) begin
              cnt <= cnt + 1'b1;
            end
          end
          S_LOW: begin
            if (is_float) begin
              state   <= S_GAP;
              cnt     <= '0;
              step_dn <= (cnt >= MIN_C);
            end else if (lvl_hi) begin
              state <= S_GAP;
              cnt   <= '0;
            end else if (us_tick && cnt < LIM_C) begin
              cnt <= cnt + 1'b1;
            end
          end
          default: begin
            if (!is_float) begin
              cnt <= '0;
            end else if (us_tick) begin
              if (cnt == GAP_C) begin
                state <= S_IDLE;
                cnt   <= '0;
              end else begin
                cnt <= cnt + 1'b1;
              end
            end
          end
        endcase
      end
    end
  end

  assert_no_step_disabled_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !(step_up || step_dn));
  assert_single_direction_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({step_up, step_dn}));
  assert_idle_under_i2c_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_IDLE && i2c_active) |=> state == S_IDLE);
  assert_short_rejected_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_HIGH && en && is_float && cnt < MIN_C) |=> !step_up);
  assert_no_start_in_gap_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_GAP) |=> !(state == S_HIGH || state == S_LOW));
endmodule

// File: rtl/vsa_code_reg.sv
module vsa_code_reg #(
  parameter int CODE_W     = 10,
  parameter int RESET_CODE = 512
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_fire,
  input  logic [CODE_W-1:0] wr_code,
  input  logic              step_up,
  input  logic              step_dn,
  input  logic [CODE_W-1:0] lo,
  input  logic [CODE_W-1:0] hi,
  output logic [CODE_W-1:0] code
);
  localparam int EXT_W = CODE_W + 2;

  logic signed [EXT_W-1:0] cand, cur;
  logic [CODE_W-1:0]       clamped;
  logic                    upd;

  assign upd = wr_fire || step_up || step_dn;

  always_comb begin
    cur = signed'({2'b00, code});
    if (wr_fire)      cand = signed'({2'b00, wr_code});
    else if (step_up) cand = cur + EXT_W'(1);
    else if (step_dn) cand = cur - EXT_W'(1);
    else              cand = cur;
  end

  vsa_clamp #(.CODE_W(CODE_W)) u_clamp (
    .cand   (cand),
    .lo     (lo),
    .hi     (hi),
    .result (clamped)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)   code <= CODE_W'(RESET_CODE);
    else if (upd) code <= clamped;
  end

  assert_in_window_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (upd && lo <= hi) |=> (code >= $past(lo) && code <= $past(hi)));
  assert_step_up_one_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (step_up && !wr_fire && code >= lo && code < hi) |=> code == $past(code) + CODE_W'(1));
  assert_step_dn_one_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (step_dn && !wr_fire && code > lo && code <= hi) |=> code == $past(code) - CODE_W'(1));
  assert_saturate_top_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (step_up && !wr_fire && code == hi) |=> code == $past(hi));
  assert_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !upd |=> $stable(code));
  assert_no_collision_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_fire && (step_up || step_dn)));
endmodule

// File: rtl/vcom_step_adjuster.sv
module vcom_step_adjuster #(
  parameter int CODE_W     = 10,
  parameter int RESET_CODE = 512,
  parameter int MIN_TICKS  = 20,
  parameter int GAP_TICKS  = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sw_enable,
  input  logic              pin_high,
  input  logic              pin_low,
  input  logic              us_tick,
  input  logic              i2c_active,
  input  logic              i2c_wr_valid,
  output logic              i2c_wr_ready,
  input  logic [CODE_W-1:0] i2c_wr_code,
  input  logic [CODE_W-1:0] win_min,
  input  logic [CODE_W-1:0] win_max,
  output logic [CODE_W-1:0] vcom_code,
  output logic              sw_busy
);
  logic step_up, step_dn, wr_fire;

  vsa_pulse_qual #(.MIN_TICKS(MIN_TICKS), .GAP_TICKS(GAP_TICKS)) u_qual (
    .clk        (clk),
    .rst_n      (rst_n),
    .en         (sw_enable),
    .lvl_hi     (pin_high),
    .lvl_lo     (pin_low),
    .us_tick    (us_tick),
    .i2c_active (i2c_active),
    .step_up    (step_up),
    .step_dn    (step_dn),
    .busy       (sw_busy)
  );

  assign i2c_wr_ready = !sw_busy;
  assign wr_fire      = i2c_wr_valid && i2c_wr_ready;

  vsa_code_reg #(.CODE_W(CODE_W), .RESET_CODE(RESET_CODE)) u_code (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_fire (wr_fire),
    .wr_code (i2c_wr_code),
    .step_up (step_up),
    .step_dn (step_dn),
    .lo      (win_min),
    .hi      (win_max),
    .code    (vcom_code)
  );

  assert_write_held_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (i2c_wr_valid && sw_busy) |=> (vcom_code == $past(vcom_code) || $past(step_up || step_dn)));
endmodule

// File: tb/tb_vcom_step_adjuster.sv
module tb_vcom_step_adjuster;
  localparam int MIN_T = 20;
  localparam int GAP_T = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sw_enable = 1'b1, pin_high = 1'b0, pin_low = 1'b0, us_tick = 1'b0;
  logic       i2c_active = 1'b0, i2c_wr_valid = 1'b0, i2c_wr_ready, sw_busy;
  logic [9:0] i2c_wr_code = '0, win_min = 10'd0, win_max = 10'd1023, vcom_code;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  vcom_step_adjuster dut (
    .clk(clk), .rst_n(rst_n), .sw_enable(sw_enable), .pin_high(pin_high),
    .pin_low(pin_low), .us_tick(us_tick), .i2c_active(i2c_active),
    .i2c_wr_valid(i2c_wr_valid), .i2c_wr_ready(i2c_wr_ready),
    .i2c_wr_code(i2c_wr_code), .win_min(win_min), .win_max(win_max),
    .vcom_code(vcom_code), .sw_busy(sw_busy)
  );

  // fields: min, max, write value, expected code
  localparam logic [39:0] VECS [8] = '{
    {10'd0,   10'd1023, 10'd300,  10'd300},
    {10'd100, 10'd900,  10'd50,   10'd100},
    {10'd100, 10'd900,  10'd950,  10'd900},
    {10'd100, 10'd900,  10'd100,  10'd100},
    {10'd100, 10'd900,  10'd900,  10'd900},
    {10'd0,   10'd1023, 10'd1023, 10'd1023},
    {10'd200, 10'd200,  10'd700,  10'd200},
    {10'd0,   10'd1023, 10'd512,  10'd512}
  };

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk) us_tick = 1'b1;
      @(negedge clk) us_tick = 1'b0;
      repeat (3) @(negedge clk);
    end
  endtask

  task automatic pulse(input bit hi, input int n);
    @(negedge clk);
    pin_high = hi;
    pin_low  = !hi;
    repeat (2) @(negedge clk);
    ticks(n);
    @(negedge clk);
    pin_high = 1'b0;
    pin_low  = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic rest();
    ticks(GAP_T);
    repeat (2) @(negedge clk);
  endtask

  task automatic wr(input logic [9:0] v);
    @(negedge clk);
    i2c_wr_valid = 1'b1;
    i2c_wr_code  = v;
    while (!i2c_wr_ready) @(negedge clk);
    @(negedge clk);
    i2c_wr_valid = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 reset code", int'(vcom_code), 512);
    chk("R1 reset busy", int'(sw_busy), 0);
    chk("R1 reset ready", int'(i2c_wr_ready), 1);

    foreach (VECS[i]) begin
      win_min = VECS[i][39:30];
      win_max = VECS[i][29:20];
      wr(VECS[i][19:10]);
      chk($sformatf("R9 write vector %0d", i), int'(vcom_code), int'(VECS[i][9:0]));
    end

    pulse(1'b1, MIN_T);
    chk("R2 high pulse steps up", int'(vcom_code), 513);
    rest();
    pulse(1'b0, MIN_T);
    chk("R3 low pulse steps down", int'(vcom_code), 512);
    rest();
    pulse(1'b1, MIN_T - 1);
    chk("R4 short pulse rejected", int'(vcom_code), 512);
    rest();

    pulse(1'b1, MIN_T);
    chk("R5 first pulse", int'(vcom_code), 513);
    ticks(GAP_T - 1);
    pulse(1'b1, MIN_T);
    chk("R5 early pulse ignored", int'(vcom_code), 513);
    rest();
    pulse(1'b0, MIN_T);
    chk("R5 pulse after full gap", int'(vcom_code), 512);
    rest();

    sw_enable = 1'b0;
    pulse(1'b1, MIN_T);
    chk("R6 disabled pin ignored", int'(vcom_code), 512);
    sw_enable = 1'b1;
    rest();

    i2c_active = 1'b1;
    pulse(1'b1, MIN_T);
    chk("R7 pulse during I2C ignored", int'(vcom_code), 512);
    i2c_active = 1'b0;
    rest();

    @(negedge clk);
    pin_high = 1'b1;
    repeat (2) @(negedge clk);
    ticks(MIN_T);
    pin_high = 1'b0;
    pin_low  = 1'b1;
    ticks(MIN_T);
    pin_low = 1'b0;
    repeat (3) @(negedge clk);
    chk("R11 level swap discarded", int'(vcom_code), 512);
    rest();

    win_max = 10'd512;
    pulse(1'b1, MIN_T);
    chk("R10 step up at max", int'(vcom_code), 512);
    rest();
    win_max = 10'd1023;
    win_min = 10'd512;
    pulse(1'b0, MIN_T);
    chk("R10 step down at min", int'(vcom_code), 512);
    rest();
    win_min = 10'd0;
    wr(10'd1023);
    pulse(1'b1, MIN_T);
    chk("R10 step up at full scale", int'(vcom_code), 1023);
    rest();
    wr(10'd0);
    pulse(1'b0, MIN_T);
    chk("R10 step down at zero", int'(vcom_code), 0);
    rest();

    // R8: write offered mid-pulse is held until the step commits
    @(negedge clk);
    pin_high = 1'b1;
    repeat (2) @(negedge clk);
    i2c_wr_valid = 1'b1;
    i2c_wr_code  = 10'd700;
    ticks(MIN_T);
    chk("R8 busy during pulse", int'(sw_busy), 1);
    chk("R8 ready low during pulse", int'(i2c_wr_ready), 0);
    chk("R8 write held", int'(vcom_code), 0);
    pin_high = 1'b0;
    @(negedge clk);
    chk("R8 busy at commit", int'(sw_busy), 1);
    @(negedge clk);
    chk("R8 step lands first", int'(vcom_code), 1);
    chk("R8 ready after step", int'(i2c_wr_ready), 1);
    @(negedge clk);
    chk("R8 held write lands", int'(vcom_code), 700);
    i2c_wr_valid = 1'b0;
    rest();

    repeat (20) @(negedge clk);
    chk("R12 code holds when idle", int'(vcom_code), 700);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule